// File: doc/BRIEF.md
# Register-Mapped GPIO With Bit-Banged Peripheral Pins

This block is a small register-mapped I/O unit with two ports, called A and D, reached through 32-bit word accesses on a simple single-cycle bus. Each port has three registers: data-out, data-in and output-enable. A few port bits are tied to external parts. On port A these are the strobes and the ready line of a NAND flash. On port D these are the serial clock and data lines of a sensor.

Software drives the NAND control lines by writing port A data-out. It bit-bangs the sensor by writing port D data-out. Any write that flips the clock bit produces a one-cycle clock event, which carries the new clock level and the data bit. Reading either data-in register returns the driven outputs masked by output-enable, with the live peripheral status bit ORed into its fixed position. Every other word in the window is plain storage. Words outside the window, and misaligned accesses, read as zero and do not store anything.

Top module: `gpio_bitbang`

## Requirements
- R1: After reset every register reads zero, the NAND strobes are low and no clock event is pending.
- R2: A word-aligned write inside the window stores the full 32-bit value. A read of any offset other than the two data-in offsets (word 0x01 and word 0x11) returns that stored value. The byte address shifted right by two gives the word offset.
- R3: A read of word 0x01 returns (word 0x00 AND word 0x02), with `nand_rdy` ORed into bit 7.
- R4: Address latch (`nand_ale`) follows bit 6 of the most recent value stored at word 0x00. Command latch (`nand_cle`) follows bit 5 and chip enable (`nand_ce`) follows bit 4. The outputs change in the cycle after the write.
- R5: A read of word 0x11 returns (word 0x10 AND word 0x12), with `sens_sdo` ORed into bit 4.
- R6: A write to word 0x10 whose bit 1 differs from the stored bit 1 raises `sens_clk_evt` for exactly the next cycle. In that cycle `sens_clk_lvl` equals the written bit 1 and `sens_data` equals the written bit 4.
- R7: A write to word 0x10 that keeps bit 1 unchanged stores the value and produces no clock event.
- R8: An access at a byte address of 0x5C or above reads zero, and a write there changes no register.
- R9: An access whose byte address is not a multiple of four reads zero, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| nand_rdy | input | 1 | NAND ready status |
| nand_ale | output | 1 | NAND address-latch strobe |
| nand_cle | output | 1 | NAND command-latch strobe |
| nand_ce | output | 1 | NAND chip enable |
| sens_sdo | input | 1 | Sensor serial output |
| sens_clk_evt | output | 1 | One-cycle clock-edge event to the sensor |
| sens_clk_lvl | output | 1 | Clock level carried by the last event |
| sens_data | output | 1 | Data bit carried by the last event |

## Verification
The bench uses the defaults: an 8-bit byte address and a 0x5C-byte window. The window therefore ends well below the top of the address space, so both the last legal word (0x58) and the out-of-range words from 0x5C to 0xFC can be reached. The port D sequence first sets the clock bit, then rewrites it unchanged, then clears it. This exercises both edge polarities and the no-change case against the same stored word.

// File: rtl/gpio_bitbang.sv
module gpio_bitbang #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 92
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              nand_rdy,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_ce,
  input  logic              sens_sdo,
  output logic              sens_clk_evt,
  output logic              sens_clk_lvl,
  output logic              sens_data
);
  localparam int WORDS = WIN_BYTES / 4;
  localparam int OFF_W = ADDR_W - 2;
  localparam logic [OFF_W-1:0] A_OUT = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] A_IN  = OFF_W'(8'h01);
  localparam logic [OFF_W-1:0] A_OE  = OFF_W'(8'h02);
  localparam logic [OFF_W-1:0] D_OUT = OFF_W'(8'h10);
  localparam logic [OFF_W-1:0] D_IN  = OFF_W'(8'h11);
  localparam logic [OFF_W-1:0] D_OE  = OFF_W'(8'h12);

  logic [31:0] regs [WORDS];
  logic [31:0] plain_rd;
  logic [OFF_W-1:0] off;
  logic hit, wr_hit;

  assign off    = bus_addr[ADDR_W-1:2];
  assign hit    = (bus_addr[1:0] == 2'b00) && (off < OFF_W'(WORDS));
  assign wr_hit = bus_wr && hit;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) regs[i] <= '0;
      else if (wr_hit && off == OFF_W'(i)) regs[i] <= bus_wdata;
    end
  end

  always_comb begin
    plain_rd = '0;
    for (int i = 0; i < WORDS; i++)
      if (off == OFF_W'(i)) plain_rd = regs[i];
  end

  always_comb begin
    if (!hit)             bus_rdata = '0;
    else if (off == A_IN) bus_rdata = (regs[A_OUT] & regs[A_OE]) | (32'(nand_rdy) << 7);
    else if (off == D_IN) bus_rdata = (regs[D_OUT] & regs[D_OE]) | (32'(sens_sdo) << 4);
    else                  bus_rdata = plain_rd;
  end

  assign nand_ale = regs[A_OUT][6];
  assign nand_cle = regs[A_OUT][5];
  assign nand_ce  = regs[A_OUT][4];

  logic clk_flip;
  assign clk_flip = wr_hit && off == D_OUT && (bus_wdata[1] != regs[D_OUT][1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sens_clk_evt <= 1'b0;
      sens_clk_lvl <= 1'b0;
      sens_data    <= 1'b0;
    end else begin
      sens_clk_evt <= clk_flip;
      if (clk_flip) begin
        sens_clk_lvl <= bus_wdata[1];
        sens_data    <= bus_wdata[4];
      end
    end
  end
endmodule

// File: rtl/gpio_bitbang_chk.sv
module gpio_bitbang_chk #(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 92
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              nand_ale,
  input logic              nand_cle,
  input logic              nand_ce,
  input logic              sens_clk_evt,
  input logic              sens_clk_lvl,
  input logic              sens_data
);
  localparam logic [ADDR_W-1:0] A_OUT_B = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] D_OUT_B = ADDR_W'(8'h40);

  p_strobe_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_OUT_B) |=> {nand_ale, nand_cle, nand_ce} == $past(bus_wdata[6:4]));

  p_strobe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_OUT_B) |=> $stable({nand_ale, nand_cle, nand_ce}));

  p_evt_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == D_OUT_B) |=> !sens_clk_evt);

  p_evt_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sens_clk_evt) |-> (sens_clk_lvl == $past(bus_wdata[1])) && (sens_data == $past(bus_wdata[4])));

  p_out_of_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(WIN_BYTES)) |-> bus_rdata == 32'd0);

  p_misaligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'd0);
endmodule

bind gpio_bitbang gpio_bitbang_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nand_ale(nand_ale),
  .nand_cle(nand_cle), .nand_ce(nand_ce), .sens_clk_evt(sens_clk_evt),
  .sens_clk_lvl(sens_clk_lvl), .sens_data(sens_data));

// File: tb/sim_gpio_bitbang.sv
module sim_gpio_bitbang;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic nand_rdy = 1'b0, sens_sdo = 1'b0;
  logic nand_ale, nand_cle, nand_ce, sens_clk_evt, sens_clk_lvl, sens_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gpio_bitbang u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nand_rdy(nand_rdy),
    .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_ce(nand_ce), .sens_sdo(sens_sdo),
    .sens_clk_evt(sens_clk_evt), .sens_clk_lvl(sens_clk_lvl), .sens_data(sens_data));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h00, d); check("R1 porta dout", d, 0);
    rd(8'h04, d); check("R1 porta din", d, 0);
    rd(8'h48, d); check("R1 portd oe", d, 0);
    check("R1 strobes", {nand_ale, nand_cle, nand_ce}, 0);
    check("R1 evt", sens_clk_evt, 0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    wr(8'h14, 32'hCAFEF00D); rd(8'h14, d); check("R2 word5", d, 32'hCAFEF00D);
    wr(8'h58, 32'hA5A55A5A); rd(8'h58, d); check("R2 last word", d, 32'hA5A55A5A);
  endtask

  task automatic t_porta;
    logic [31:0] d;
    wr(8'h08, 32'hFF00FF0F);
    wr(8'h00, 32'h12345678);
    check("R4 strobes 111", {nand_ale, nand_cle, nand_ce}, 3'b111);
    rd(8'h00, d); check("R2 porta dout stored", d, 32'h12345678);
    nand_rdy = 1'b0; rd(8'h04, d); check("R3 din rdy0", d, 32'h12005608);
    nand_rdy = 1'b1; rd(8'h04, d); check("R3 din rdy1", d, 32'h12005688);
    wr(8'h00, 32'h00000040);
    check("R4 strobes 100", {nand_ale, nand_cle, nand_ce}, 3'b100);
    wr(8'h00, 32'h00000020);
    check("R4 strobes 010", {nand_ale, nand_cle, nand_ce}, 3'b010);
  endtask

  task automatic t_portd;
    logic [31:0] d;
    wr(8'h48, 32'h0000000F);
    check("R7 no evt on oe write", sens_clk_evt, 0);
    wr(8'h40, 32'h00000012);
    check("R6 rise evt", {sens_clk_evt, sens_clk_lvl, sens_data}, 3'b111);
    @(negedge clk); check("R6 one cycle", sens_clk_evt, 0);
    sens_sdo = 1'b1; rd(8'h44, d); check("R5 din sdo1", d, 32'h12);
    sens_sdo = 1'b0; rd(8'h44, d); check("R5 din sdo0", d, 32'h02);
    wr(8'h40, 32'h00000013);
    check("R7 no evt same clk", sens_clk_evt, 0);
    rd(8'h40, d); check("R7 stored", d, 32'h13);
    wr(8'h40, 32'h00000001);
    check("R6 fall evt", {sens_clk_evt, sens_clk_lvl, sens_data}, 3'b100);
  endtask

  task automatic t_oob;
    logic [31:0] d;
    wr(8'h5C, 32'hDEADBEEF);
    rd(8'h5C, d); check("R8 read 0x5C", d, 0);
    rd(8'hFC, d); check("R8 read 0xFC", d, 0);
    rd(8'h58, d); check("R8 last word intact", d, 32'hA5A55A5A);
    wr(8'hC0, 32'h00000002);
    check("R8 no evt alias", sens_clk_evt, 0);
  endtask

  task automatic t_misalign;
    logic [31:0] d;
    wr(8'h15, 32'h11111111);
    rd(8'h14, d); check("R9 word intact", d, 32'hCAFEF00D);
    rd(8'h15, d); check("R9 read zero", d, 0);
    wr(8'h41, 32'h00000002);
    check("R9 no evt", sens_clk_evt, 0);
    rd(8'h40, d); check("R9 portd intact", d, 32'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_porta();
    t_portd();
    t_oob();
    t_misalign();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule